// File: doc/BRIEF.md
# Per-Channel Silence Flag Detector

This block watches a stereo audio stream and reports, separately for the left and right channels, when a channel has been silent long enough to count as idle. It is meant to sit behind the serial receivers of a playback path. The receivers hand it either word samples with a frame strobe, or one-bit delta-sigma stream bits with a bit strobe. The two flags it produces can drive indicator pins or start an automatic mute elsewhere in the chip.

The `mode` input selects which rule applies. For word samples the rule is a run of consecutive frames whose value is exactly zero. The run is longer at the 8x oversampled rate than at the base rate. For the one-bit stream the rule is how long an 8-bit idle pattern keeps repeating, measured in bits. That length doubles when the stream runs at twice the base bit rate. Each flag rises once its channel's run reaches the threshold for the current mode. Any break in a channel's run clears only that channel's flag. A polarity input sets whether an active flag reads as 1 or as 0.

Top module: `silence_flag_det`

## Requirements
- R1: With `mode` = 0 (word rate), a channel's flag becomes active in the cycle after the strobe of its PCM_RUN-th consecutive all-zero frame, and not before. A frame is a cycle with `smp_valid` = 1.
- R2: With `mode` = 1 (8x oversampled words), the run needed is EF_RUN consecutive all-zero frames.
- R3: With `mode` = 2 (one-bit stream), a channel counts one idle bit for each `dsd_valid` strobe at which the last 8 bits, including the current one, form a cyclic rotation of IDLE_PAT (default 0x69). The first 7 bits after a clear cannot count. The flag becomes active in the cycle after the DSD_RUN-th consecutive idle bit.
- R4: With `mode` = 3 (one-bit stream at twice the bit rate), the idle rule of R3 applies with a run of 2*DSD_RUN bits.
- R5: The left and right channels are judged independently, and a break on one channel never changes the other channel's flag.
- R6: `flag_pol` = 0 drives an active flag as 1 and an inactive flag as 0; `flag_pol` = 1 inverts both outputs.
- R7: A non-zero frame, or a strobed bit that is not idle under R3, clears that channel's run and makes its flag inactive in the next cycle.
- R8: The run count saturates at the threshold, so the flag stays active for any length of continued silence.
- R9: While `rst_n` is low, both runs are cleared and both flags are inactive.
- R10: In any cycle where `mode` differs from its value in the previous cycle, both runs, the 8-bit pattern windows and both flags are cleared.
- R11: Strobes of the kind the current mode does not use are ignored: `dsd_valid` in modes 0 and 1, and `smp_valid` in modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 word rate, 1 8x oversampled words, 2 one-bit stream, 3 one-bit stream at twice the rate |
| flag_pol | input | 1 | 0: active flag reads 1; 1: active flag reads 0 |
| smp_valid | input | 1 | Frame strobe for word samples |
| smp_left | input | SMP_W | Left word sample, two's complement |
| smp_right | input | SMP_W | Right word sample, two's complement |
| dsd_valid | input | 1 | Bit strobe for the one-bit streams |
| dsd_left | input | 1 | Left stream bit |
| dsd_right | input | 1 | Right stream bit |
| zero_l | output | 1 | Left silence flag |
| zero_r | output | 1 | Right silence flag |

## Verification
The checker verifies on every cycle several properties. A broken run or a mode change makes the flag inactive on the next cycle. An active flag stays active until a break. A flag can only rise right after a strobe that extends the run. Reset leaves both flags inactive. Only the bench scenarios can show that the flag rises at exactly the right run length for each of the four modes, that the pattern window needs 7 bits of history, that the two channels stay apart, and that polarity inverts the outputs; the bench does this by comparing against a model of the requirements through long random runs with occasional breaks and mode changes.

// File: rtl/silflag_pkg.sv
package silflag_pkg;

  typedef enum logic [1:0] {
    SF_WORD   = 2'd0,
    SF_OVS8   = 2'd1,
    SF_BIT1X  = 2'd2,
    SF_BIT2X  = 2'd3
  } sf_mode_e;

  function automatic logic sf_is_word(sf_mode_e m);
    return (m == SF_WORD) || (m == SF_OVS8);
  endfunction

endpackage

// File: rtl/sf_idle_match.sv
module sf_idle_match #(
  parameter int          PAT_W = 8,
  parameter logic [7:0]  PAT   = 8'h69
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic idle
);

  localparam int FW = $clog2(PAT_W);
  localparam logic [FW-1:0] FILL_MAX = FW'(PAT_W - 1);
  localparam logic [2*PAT_W-1:0] DBL = {PAT[PAT_W-1:0], PAT[PAT_W-1:0]};

  logic [PAT_W-2:0] win_q, win_d;
  logic [FW-1:0]    fill_q, fill_d;
  logic [PAT_W-1:0] cand;
  logic [PAT_W-1:0] rot_hit;

  assign cand = {win_q, bit_in};

  for (genvar k = 0; k < PAT_W; k++) begin : g_rot
    localparam logic [PAT_W-1:0] ROT = DBL[2*PAT_W-1-k -: PAT_W];
    assign rot_hit[k] = (cand == ROT);
  end

  assign idle = (fill_q == FILL_MAX) && (|rot_hit);

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    if (clr) begin
      win_d  = '0;
      fill_d = '0;
    end else if (bit_vld) begin
      win_d = cand[PAT_W-2:0];
      if (fill_q != FILL_MAX) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/sf_run_cnt.sv
module sf_run_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          hit,
  input  logic [CW-1:0] limit,
  output logic          flag
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      if (!hit)                cnt_d = '0;
      else if (cnt_q != limit) cnt_d = cnt_q + 1'b1;
    end
    flag_d = (cnt_d == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flag  <= flag_d;
    end
  end

endmodule

// File: rtl/silence_flag_det.sv
module silence_flag_det
  import silflag_pkg::*;
#(
  parameter int         SMP_W    = 24,
  parameter int         PCM_RUN  = 1024,
  parameter int         EF_RUN   = 8192,
  parameter int         DSD_RUN  = 62092,
  parameter logic [7:0] IDLE_PAT = 8'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             flag_pol,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  input  logic             dsd_valid,
  input  logic             dsd_left,
  input  logic             dsd_right,
  output logic             zero_l,
  output logic             zero_r
);

  localparam int RUN_A   = (PCM_RUN > EF_RUN) ? PCM_RUN : EF_RUN;
  localparam int MAX_RUN = (RUN_A > 2*DSD_RUN) ? RUN_A : 2*DSD_RUN;
  localparam int CW      = $clog2(MAX_RUN + 1);

  sf_mode_e      cur_mode, mode_q;
  logic          mode_chg;
  logic          word_mode;
  logic [CW-1:0] limit;

  logic [SMP_W-1:0] word_v [2];
  logic [1:0]       bit_v;
  logic [1:0]       idle_v;
  logic [1:0]       step_v;
  logic [1:0]       hit_v;
  logic [1:0]       flag_v;

  assign cur_mode  = sf_mode_e'(mode);
  assign mode_chg  = (cur_mode != mode_q);
  assign word_mode = sf_is_word(cur_mode);

  assign word_v[0] = smp_left;
  assign word_v[1] = smp_right;
  assign bit_v     = {dsd_right, dsd_left};

  always_comb begin
    unique case (cur_mode)
      SF_WORD:  limit = CW'(PCM_RUN);
      SF_OVS8:  limit = CW'(EF_RUN);
      SF_BIT1X: limit = CW'(DSD_RUN);
      default:  limit = CW'(2 * DSD_RUN);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SF_WORD;
    else        mode_q <= cur_mode;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    sf_idle_match #(
      .PAT_W (8),
      .PAT   (IDLE_PAT)
    ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mode_chg),
      .bit_vld (dsd_valid & ~word_mode),
      .bit_in  (bit_v[ch]),
      .idle    (idle_v[ch])
    );

    assign step_v[ch] = word_mode ? smp_valid : dsd_valid;
    assign hit_v[ch]  = word_mode ? (word_v[ch] == '0) : idle_v[ch];

    sf_run_cnt #(
      .CW (CW)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mode_chg),
      .step  (step_v[ch]),
      .hit   (hit_v[ch]),
      .limit (limit),
      .flag  (flag_v[ch])
    );
  end

  assign zero_l = flag_v[0] ^ flag_pol;
  assign zero_r = flag_v[1] ^ flag_pol;

endmodule

// File: rtl/silence_flag_det_chk.sv
module silence_flag_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       flag_pol,
  input logic [1:0] step_v,
  input logic [1:0] hit_v,
  input logic       zero_l,
  input logic       zero_r
);

  logic act_l, act_r;
  assign act_l = zero_l ^ flag_pol;
  assign act_r = zero_r ^ flag_pol;

  // R7: a broken run drops the flag next cycle
  a_r7_break_l: assert property (@(posedge clk) disable iff (!rst_n)
    (step_v[0] && !hit_v[0]) |=> !act_l);
  a_r7_break_r: assert property (@(posedge clk) disable iff (!rst_n)
    (step_v[1] && !hit_v[1]) |=> !act_r);

  // R8 and R5: an active flag holds until its own channel breaks
  a_r8_hold_l: assert property (@(posedge clk) disable iff (!rst_n)
    (act_l && !(step_v[0] && !hit_v[0]) && (mode == $past(mode))) |=> act_l);
  a_r5_hold_r: assert property (@(posedge clk) disable iff (!rst_n)
    (act_r && !(step_v[1] && !hit_v[1]) && (mode == $past(mode))) |=> act_r);

  // R10: a mode change clears both flags
  a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |=> (!act_l && !act_r));

  // R11: a flag rises only after a strobe that extends the run
  a_r11_rise_l: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_l) |-> $past(step_v[0] && hit_v[0]));
  a_r11_rise_r: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_r) |-> $past(step_v[1] && hit_v[1]));

  // R9: reset leaves both flags inactive
  a_r9_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!act_l && !act_r));

endmodule

bind silence_flag_det silence_flag_det_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .flag_pol (flag_pol),
  .step_v   (step_v),
  .hit_v    (hit_v),
  .zero_l   (zero_l),
  .zero_r   (zero_r)
);

// File: tb/sim_silence_flag_det.sv
module sim_silence_flag_det;

  localparam int SW = 12;
  localparam int PR = 16;
  localparam int ER = 40;
  localparam int DR = 30;
  localparam logic [7:0] PAT = 8'h69;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          pol;
  logic          smp_valid;
  logic [SW-1:0] smp_left, smp_right;
  logic          dsd_valid, dsd_left, dsd_right;
  logic          zero_l, zero_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int       m_cnt  [2];
  int       m_fill [2];
  logic [7:0] m_win [2];
  bit       m_flag [2];
  logic [1:0] m_prev;

  always #4 clk = ~clk;

  silence_flag_det #(
    .SMP_W(SW), .PCM_RUN(PR), .EF_RUN(ER), .DSD_RUN(DR), .IDLE_PAT(PAT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .flag_pol(pol),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .dsd_valid(dsd_valid), .dsd_left(dsd_left), .dsd_right(dsd_right),
    .zero_l(zero_l), .zero_r(zero_r)
  );

  function automatic int limit_of(logic [1:0] md);
    case (md)
      2'd0:    return PR;
      2'd1:    return ER;
      2'd2:    return DR;
      default: return 2 * DR;
    endcase
  endfunction

  function automatic bit is_rot(logic [7:0] w);
    logic [15:0] d = {PAT, PAT};
    for (int k = 0; k < 8; k++) if (w == d[15-k -: 8]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic pat_bit(int i);
    return PAT[7 - (i % 8)];
  endfunction

  task automatic model_step();
    bit chg;
    if (!rst_n) begin
      m_prev = 2'd0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_fill[c] = 0; m_win[c] = '0; m_flag[c] = 0;
      end
      return;
    end
    chg = (mode != m_prev);
    m_prev = mode;
    for (int c = 0; c < 2; c++) begin
      int lim = limit_of(mode);
      if (chg) begin
        m_cnt[c] = 0; m_fill[c] = 0; m_win[c] = '0;
      end else if (mode < 2'd2) begin
        if (smp_valid) begin
          logic [SW-1:0] w = (c == 0) ? smp_left : smp_right;
          m_cnt[c] = (w == '0) ? ((m_cnt[c] < lim) ? m_cnt[c] + 1 : lim) : 0;
        end
      end else if (dsd_valid) begin
        logic b = (c == 0) ? dsd_left : dsd_right;
        bit idle;
        m_win[c] = {m_win[c][6:0], b};
        idle = (m_fill[c] >= 7) && is_rot(m_win[c]);
        if (m_fill[c] < 7) m_fill[c]++;
        m_cnt[c] = idle ? ((m_cnt[c] < lim) ? m_cnt[c] + 1 : lim) : 0;
      end
      m_flag[c] = (m_cnt[c] == lim);
    end
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, zero_l, logic'(m_flag[0]) ^ pol);
    check(tag, zero_r, logic'(m_flag[1]) ^ pol);
  endtask

  task automatic frame(string tag, logic [SW-1:0] l, logic [SW-1:0] r);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    tick(tag);
    smp_valid = 1'b0;
  endtask

  task automatic dbit(string tag, logic bl, logic br);
    dsd_valid = 1'b1; dsd_left = bl; dsd_right = br;
    tick(tag);
    dsd_valid = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ph;
    void'($urandom(32'd24681));
    rst_n = 1'b0; mode = 2'd0; pol = 1'b0;
    smp_valid = 0; smp_left = '0; smp_right = '0;
    dsd_valid = 0; dsd_left = 0; dsd_right = 0;
    model_step();
    @(negedge clk); @(negedge clk);
    check("R9", zero_l, 1'b0);
    check("R9", zero_r, 1'b0);
    pol = 1'b1; #1;
    check("R9 R6", zero_l, 1'b1);
    pol = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tick("R9");

    // R1 word-rate threshold, with idle gaps between frames
    for (int i = 0; i < PR - 1; i++) begin
      frame("R1", '0, '0);
      tick("R1");
    end
    check("R1 one short", zero_l, 1'b0);
    frame("R1", '0, '0);
    check("R1 reached", zero_l, 1'b1);
    check("R1 reached", zero_r, 1'b1);

    // R5 right break leaves left alone
    frame("R5", '0, 12'd5);
    check("R5 left", zero_l, 1'b1);
    check("R5 right", zero_r, 1'b0);

    // R11 bit strobes ignored in word mode
    for (int i = 0; i < 40; i++) dbit("R11", 1'b1, 1'b0);
    check("R11", zero_l, 1'b1);
    check("R11", zero_r, 1'b0);

    // R8 saturation
    for (int i = 0; i < 3 * PR; i++) frame("R8", '0, '0);
    check("R8", zero_l, 1'b1);
    check("R8", zero_r, 1'b1);

    // R7 negative minimum value breaks
    frame("R7", 12'h800, '0);
    check("R7", zero_l, 1'b0);
    check("R7", zero_r, 1'b1);

    // R10 mode change clears
    mode = 2'd1;
    tick("R10");
    check("R10", zero_r, 1'b0);

    // R2 oversampled threshold
    for (int i = 0; i < ER - 1; i++) frame("R2", '0, '0);
    check("R2 one short", zero_l, 1'b0);
    frame("R2", '0, '0);
    check("R2 reached", zero_l, 1'b1);

    // R6 polarity
    pol = 1'b1;
    tick("R6");
    check("R6", zero_l, 1'b0);
    pol = 1'b0;

    // R3 one-bit stream, right channel at another phase
    mode = 2'd2;
    tick("R10");
    for (int i = 0; i < 7 + DR - 1; i++) dbit("R3", pat_bit(i), pat_bit(i + 3));
    check("R3 one short", zero_l, 1'b0);
    dbit("R3", pat_bit(7 + DR - 1), pat_bit(7 + DR + 2));
    check("R3 reached", zero_l, 1'b1);
    check("R3 reached", zero_r, 1'b1);

    // R11 word strobes ignored in bit mode
    frame("R11", 12'h7FF, 12'h001);
    check("R11", zero_l, 1'b1);

    // R7 one flipped bit breaks the pattern
    dbit("R7", ~pat_bit(7 + DR), pat_bit(7 + DR + 3));
    check("R7", zero_l, 1'b0);
    check("R5", zero_r, 1'b1);

    // R4 double-rate threshold
    mode = 2'd3;
    tick("R10");
    for (int i = 0; i < 7 + DR; i++) dbit("R4", pat_bit(i), pat_bit(i));
    check("R4 not at 1x run", zero_l, 1'b0);
    for (int i = 7 + DR; i < 7 + 2 * DR - 1; i++) dbit("R4", pat_bit(i), pat_bit(i));
    check("R4 one short", zero_l, 1'b0);
    dbit("R4", pat_bit(7 + 2 * DR - 1), pat_bit(7 + 2 * DR - 1));
    check("R4 reached", zero_l, 1'b1);

    // random phase
    ph = 0;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(499) == 0) mode = 2'($urandom_range(3));
      if ($urandom_range(299) == 0) pol = ~pol;
      smp_valid = ($urandom_range(3) != 0);
      smp_left  = ($urandom_range(63) == 0) ? SW'($urandom) : '0;
      smp_right = ($urandom_range(63) == 0) ? SW'($urandom) : '0;
      dsd_valid = ($urandom_range(3) != 0);
      dsd_left  = ($urandom_range(255) == 0) ? 1'($urandom) : pat_bit(ph);
      dsd_right = ($urandom_range(255) == 0) ? 1'($urandom) : pat_bit(ph + 5);
      if (dsd_valid) ph++;
      tick("RND R1 R2 R3 R4 R7 R10");
    end
    smp_valid = 0; dsd_valid = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule